// File: doc/BRIEF.md
# I2C Register-Access Slave Interface

This block is the serial front end of a peripheral with one small register bank. It watches SCL and SDA, which have already been synchronised into the system clock domain. Each line first passes through a glitch filter with a configurable cycle count. The block then finds START, repeated START and STOP conditions and shifts bytes MSB first. It controls SDA only through an open-drain pull-down enable. A transaction opens with an identification byte. The upper five bits of that byte are a fixed prefix. The next bit must equal a board-strapped pin, which is captured at START. A fixed zero follows, and the last bit selects read or write.

A write carries one register address byte and one data byte. The data byte appears on the register port as a single-cycle write strobe. A read first sets the address with a write-form identification and an address byte. A repeated START and a read-form identification follow, and the block then streams data bytes from the register port for as long as the master acknowledges them. A one-cycle strobe after STOP marks the end of a transaction that wrote a register. START conditions are ignored while a power-up busy input is high.

The controller is an enumerated state machine:
- `S_IDLE` waits for START.
- `S_ID_RX` takes the identification byte. It goes to `S_ID_ACK` on a match and back to `S_IDLE` otherwise.
- `S_ID_ACK` goes to `S_ADDR_RX` for a write or to `S_RD_TX` for a read.
- The write path runs `S_ADDR_RX` → `S_ADDR_ACK` → `S_WR_RX` → `S_WR_ACK` → `S_HOLD`.
- The read path runs `S_RD_TX` → `S_RD_MACK`. It returns to `S_RD_TX` when the master ACKs and goes to `S_HOLD` when the master NACKs.
- From any state, STOP leads to `S_IDLE` and an accepted START leads to `S_ID_RX`.

Top module: `i2c_regport_slave`

## Requirements
- R1: While reset is asserted and directly after it, `sda_drive_low`, `reg_we` and `stop_pulse` are 0.
- R2: The block acknowledges an identification byte only if its bits 7..3 equal `ID_PREFIX` (default 01010), bit 2 equals the latched pin value and bit 1 is 0. Bit 0 is R/W, where 1 means read. Any other byte gets no ACK, and the following bytes get no ACK either until the next START.
- R3: `addr_pin` is sampled at each accepted START and held for the whole transaction. A change after START has no effect on the match.
- R4: In a write, the block acknowledges the address byte and the data byte. It then raises `reg_we` for exactly one cycle, with `reg_addr` holding the address and `reg_wdata` holding the data, both received MSB first.
- R5: Data bytes after the first one in a write get no ACK and produce no further `reg_we`.
- R6: After a repeated START with a read identification, the block transmits `reg_rdata` MSB first. It samples `reg_rdata` at the start of each byte, at the current `reg_addr`.
- R7: Reading continues while the master ACKs in the ninth clock. After a NACK the block releases SDA until STOP or START.
- R8: `stop_pulse` is high for one cycle after a STOP, but only when the finished transaction wrote a register. A STOP that ends a read or a rejected transaction gives no pulse.
- R9: While `powerup_busy` is 1, START conditions are ignored and the block does not respond.
- R10: A level on SCL or SDA that lasts fewer than `FILT_CYCLES` clock cycles is filtered out.
- R11: `sda_drive_low` changes only while the filtered SCL is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| scl_in | input | 1 | Synchronised SCL level |
| sda_in | input | 1 | Synchronised SDA bus level |
| addr_pin | input | 1 | Strapped bit 2 of the identification byte |
| powerup_busy | input | 1 | High while the START conditions must be ignored |
| sda_drive_low | output | 1 | Open-drain enable, 1 pulls SDA low |
| reg_addr | output | 8 | Register address from the last address byte |
| reg_wdata | output | 8 | Write data byte |
| reg_we | output | 1 | One-cycle register write strobe |
| reg_rdata | input | 8 | Read data for `reg_addr` |
| stop_pulse | output | 1 | One-cycle strobe after the STOP of a write transaction |

## Verification
The bench builds the block with `FILT_CYCLES` = 3 and the default prefix 01010. It drives the bus with a quarter period of 10 clocks. With this short filter, a 2-cycle SCL spike inside an address byte falls just below the rejection threshold. If the filter is weakened, that spike adds a bit and shifts the address. Because the bus quarter period is far longer than the filter delay, the ACK timing and the read-bit timing can be checked at mid-high-phase sample points. These checks use strapped-pin values of both 0 and 1.

// File: rtl/i2cs_pkg.sv
package i2cs_pkg;
    localparam int BYTE_W = 8;
    localparam int CNT_W  = $clog2(BYTE_W + 1);

    typedef enum logic [3:0] {
        S_IDLE,
        S_ID_RX,
        S_ID_ACK,
        S_ADDR_RX,
        S_ADDR_ACK,
        S_WR_RX,
        S_WR_ACK,
        S_RD_TX,
        S_RD_MACK,
        S_HOLD
    } state_t;
endpackage

// File: rtl/i2cs_deglitch.sv
module i2cs_deglitch #(
    parameter int CYCLES = 13
) (
    input  logic clk,
    input  logic rst_n,
    input  logic raw_in,
    output logic clean_out
);
    localparam int CW = $clog2(CYCLES + 1);
    localparam logic [CW-1:0] LAST = CW'(CYCLES - 1);

    logic [CW-1:0] run_len;

    // A new level is accepted only after CYCLES consecutive differing samples.
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            clean_out <= 1'b1;
            run_len   <= '0;
        end else if (raw_in == clean_out) begin
            run_len <= '0;
        end else if (run_len == LAST) begin
            clean_out <= raw_in;
            run_len   <= '0;
        end else begin
            run_len <= run_len + 1'b1;
        end
    end

    a_r10_no_early_change: assert property (@(posedge clk) disable iff (!rst_n)
        (raw_in == clean_out) |=> $stable(clean_out));
endmodule

// File: rtl/i2cs_bus_events.sv
module i2cs_bus_events (
    input  logic clk,
    input  logic rst_n,
    input  logic scl_c,
    input  logic sda_c,
    output logic scl_rise,
    output logic scl_fall,
    output logic ev_start,
    output logic ev_stop
);
    logic scl_d, sda_d;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            scl_d <= 1'b1;
            sda_d <= 1'b1;
        end else begin
            scl_d <= scl_c;
            sda_d <= sda_c;
        end
    end

    assign scl_rise = scl_c & ~scl_d;
    assign scl_fall = ~scl_c & scl_d;
    assign ev_start = scl_c & scl_d & sda_d & ~sda_c;
    assign ev_stop  = scl_c & scl_d & ~sda_d & sda_c;

    a_r11_no_start_and_stop: assert property (@(posedge clk) disable iff (!rst_n)
        !(ev_start && ev_stop));
endmodule

// File: rtl/i2cs_frame_ctrl.sv
module i2cs_frame_ctrl
    import i2cs_pkg::*;
#(
    parameter logic [4:0] ID_PREFIX = 5'b01010
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              scl_c,
    input  logic              sda_c,
    input  logic              scl_rise,
    input  logic              scl_fall,
    input  logic              ev_start,
    input  logic              ev_stop,
    input  logic              addr_pin,
    input  logic              powerup_busy,
    input  logic [BYTE_W-1:0] reg_rdata,
    output logic              sda_drive_low,
    output logic [BYTE_W-1:0] reg_addr,
    output logic [BYTE_W-1:0] reg_wdata,
    output logic              reg_we,
    output logic              stop_pulse
);
    localparam logic [CNT_W-1:0] FULL = CNT_W'(BYTE_W);
    localparam logic [CNT_W-1:0] LAST = CNT_W'(BYTE_W - 1);

    state_t              state, nxt;
    logic [BYTE_W-1:0]   shreg;
    logic [CNT_W-1:0]    bitcnt;
    logic                rw_q, a1_q, wrote_q, mack_q;
    logic                start_ok, id_match, byte_done;

    assign start_ok  = ev_start & ~powerup_busy;
    assign byte_done = scl_fall && (bitcnt == FULL);
    assign id_match  = (shreg[7:3] == ID_PREFIX) && (shreg[2] == a1_q) && !shreg[1];

    // next-state logic
    always_comb begin
        nxt = state;
        if (ev_stop) begin
            nxt = S_IDLE;
        end else if (start_ok) begin
            nxt = S_ID_RX;
        end else begin
            unique case (state)
                S_IDLE:     nxt = S_IDLE;
                S_ID_RX:    if (byte_done) nxt = id_match ? S_ID_ACK : S_IDLE;
                S_ID_ACK:   if (scl_fall) nxt = rw_q ? S_RD_TX : S_ADDR_RX;
                S_ADDR_RX:  if (byte_done) nxt = S_ADDR_ACK;
                S_ADDR_ACK: if (scl_fall) nxt = S_WR_RX;
                S_WR_RX:    if (byte_done) nxt = S_WR_ACK;
                S_WR_ACK:   if (scl_fall) nxt = S_HOLD;
                S_RD_TX:    if (scl_fall && bitcnt == LAST) nxt = S_RD_MACK;
                S_RD_MACK:  if (scl_fall) nxt = mack_q ? S_RD_TX : S_HOLD;
                S_HOLD:     nxt = S_HOLD;
                default:    nxt = S_IDLE;
            endcase
        end
    end

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state <= S_IDLE;
        else        state <= nxt;
    end

    // datapath and registered outputs
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            shreg      <= '0;
            bitcnt     <= '0;
            rw_q       <= 1'b0;
            a1_q       <= 1'b0;
            wrote_q    <= 1'b0;
            mack_q     <= 1'b0;
            reg_addr   <= '0;
            reg_wdata  <= '0;
            reg_we     <= 1'b0;
            stop_pulse <= 1'b0;
        end else begin
            reg_we     <= 1'b0;
            stop_pulse <= 1'b0;
            if (ev_stop) begin
                stop_pulse <= wrote_q;
                wrote_q    <= 1'b0;
            end else if (start_ok) begin
                a1_q   <= addr_pin;
                bitcnt <= '0;
            end else begin
                unique case (state)
                    S_ID_RX, S_ADDR_RX, S_WR_RX: begin
                        if (scl_rise) begin
                            shreg  <= {shreg[BYTE_W-2:0], sda_c};
                            bitcnt <= bitcnt + 1'b1;
                        end else if (byte_done) begin
                            bitcnt <= '0;
                            if (state == S_ID_RX)   rw_q <= shreg[0];
                            if (state == S_ADDR_RX) reg_addr <= shreg;
                            if (state == S_WR_RX) begin
                                reg_wdata <= shreg;
                                reg_we    <= 1'b1;
                                wrote_q   <= 1'b1;
                            end
                        end
                    end
                    S_ID_ACK: begin
                        if (scl_fall && rw_q) begin
                            shreg  <= reg_rdata;
                            bitcnt <= '0;
                        end
                    end
                    S_RD_TX: begin
                        if (scl_fall) begin
                            shreg  <= {shreg[BYTE_W-2:0], 1'b1};
                            bitcnt <= bitcnt + 1'b1;
                        end
                    end
                    S_RD_MACK: begin
                        if (scl_rise) mack_q <= ~sda_c;
                        else if (scl_fall && mack_q) begin
                            shreg  <= reg_rdata;
                            bitcnt <= '0;
                        end
                    end
                    default: ;
                endcase
            end
        end
    end

    // open-drain drive
    always_comb begin
        unique case (state)
            S_ID_ACK, S_ADDR_ACK, S_WR_ACK: sda_drive_low = 1'b1;
            S_RD_TX:                        sda_drive_low = ~shreg[BYTE_W-1];
            default:                        sda_drive_low = 1'b0;
        endcase
    end

    a_r11_sda_steady_scl_high: assert property (@(posedge clk) disable iff (!rst_n)
        (scl_c && $past(scl_c)) |-> $stable(sda_drive_low));
    a_r4_we_one_cycle: assert property (@(posedge clk) disable iff (!rst_n)
        reg_we |=> !reg_we);
    a_r8_stop_one_cycle: assert property (@(posedge clk) disable iff (!rst_n)
        stop_pulse |=> !stop_pulse);
    a_r8_stop_after_bus_stop: assert property (@(posedge clk) disable iff (!rst_n)
        stop_pulse |-> $past(ev_stop));
    a_r9_busy_blocks_start: assert property (@(posedge clk) disable iff (!rst_n)
        (powerup_busy && ev_start && state == S_IDLE) |=> state == S_IDLE);
    a_r2_idle_released: assert property (@(posedge clk) disable iff (!rst_n)
        (state == S_IDLE || state == S_HOLD) |-> !sda_drive_low);
endmodule

// File: rtl/i2c_regport_slave.sv
module i2c_regport_slave #(
    parameter int         FILT_CYCLES = 13,
    parameter logic [4:0] ID_PREFIX   = 5'b01010
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       scl_in,
    input  logic       sda_in,
    input  logic       addr_pin,
    input  logic       powerup_busy,
    output logic       sda_drive_low,
    output logic [7:0] reg_addr,
    output logic [7:0] reg_wdata,
    output logic       reg_we,
    input  logic [7:0] reg_rdata,
    output logic       stop_pulse
);
    localparam int LINES = 2;

    logic [LINES-1:0] raw_lines, clean_lines;
    logic scl_rise, scl_fall, ev_start, ev_stop;

    assign raw_lines = {sda_in, scl_in};

    generate
        for (genvar g = 0; g < LINES; g++) begin : g_filt
            i2cs_deglitch #(.CYCLES(FILT_CYCLES)) u_filt (
                .clk       (clk),
                .rst_n     (rst_n),
                .raw_in    (raw_lines[g]),
                .clean_out (clean_lines[g])
            );
        end
    endgenerate

    i2cs_bus_events u_events (
        .clk      (clk),
        .rst_n    (rst_n),
        .scl_c    (clean_lines[0]),
        .sda_c    (clean_lines[1]),
        .scl_rise (scl_rise),
        .scl_fall (scl_fall),
        .ev_start (ev_start),
        .ev_stop  (ev_stop)
    );

    i2cs_frame_ctrl #(.ID_PREFIX(ID_PREFIX)) u_ctrl (
        .clk           (clk),
        .rst_n         (rst_n),
        .scl_c         (clean_lines[0]),
        .sda_c         (clean_lines[1]),
        .scl_rise      (scl_rise),
        .scl_fall      (scl_fall),
        .ev_start      (ev_start),
        .ev_stop       (ev_stop),
        .addr_pin      (addr_pin),
        .powerup_busy  (powerup_busy),
        .reg_rdata     (reg_rdata),
        .sda_drive_low (sda_drive_low),
        .reg_addr      (reg_addr),
        .reg_wdata     (reg_wdata),
        .reg_we        (reg_we),
        .stop_pulse    (stop_pulse)
    );
endmodule

// File: tb/i2c_regport_slave_bench.sv
module i2c_regport_slave_bench;
    localparam int Q = 10;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic scl_m = 1'b1, sda_m = 1'b1;
    logic addr_pin = 1'b0, busy = 1'b0;
    logic [7:0] rd_seed = 8'h00;
    logic sda_drive_low, reg_we, stop_pulse;
    logic [7:0] reg_addr, reg_wdata, reg_rdata;
    wire sda_bus = sda_m & ~sda_drive_low;

    int n_chk = 0, n_fail = 0, stops_seen = 0, stops_exp = 0, r11_bad = 0;
    logic [15:0] exp_wr[$];

    assign reg_rdata = reg_addr + rd_seed;

    always #2 clk = ~clk;

    i2c_regport_slave #(.FILT_CYCLES(3)) u_i2c_regport_slave (
        .clk(clk), .rst_n(rst_n), .scl_in(scl_m), .sda_in(sda_bus),
        .addr_pin(addr_pin), .powerup_busy(busy), .sda_drive_low(sda_drive_low),
        .reg_addr(reg_addr), .reg_wdata(reg_wdata), .reg_we(reg_we),
        .reg_rdata(reg_rdata), .stop_pulse(stop_pulse));

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    // reference of register writes, compared on every clock
    always @(negedge clk) begin
        if (rst_n && reg_we) begin
            n_chk++;
            if (exp_wr.size() == 0) begin
                n_fail++;
                $display("FAIL R4/R5 unexpected write actual=%0h expected=none", {reg_addr, reg_wdata});
            end else begin
                logic [15:0] e;
                e = exp_wr.pop_front();
                if ({reg_addr, reg_wdata} !== e) begin
                    n_fail++;
                    $display("FAIL R4 write actual=%0h expected=%0h", {reg_addr, reg_wdata}, e);
                end
            end
        end
        if (rst_n && stop_pulse) stops_seen++;
    end

    task automatic w(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic bus_start();
        sda_m = 1'b1; w(Q); scl_m = 1'b1; w(Q); sda_m = 1'b0; w(Q); scl_m = 1'b0; w(Q);
    endtask

    task automatic bus_stop();
        sda_m = 1'b0; w(Q); scl_m = 1'b1; w(Q); sda_m = 1'b1; w(2 * Q);
    endtask

    task automatic send_byte(input logic [7:0] b, input bit glitch, output bit acked);
        for (int i = 7; i >= 0; i--) begin
            sda_m = b[i];
            if (glitch && i == 5) begin
                w(3); scl_m = 1'b1; w(2); scl_m = 1'b0; w(Q - 5);
            end else begin
                w(Q);
            end
            scl_m = 1'b1; w(2 * Q); scl_m = 1'b0; w(Q);
        end
        sda_m = 1'b1; w(Q); scl_m = 1'b1; w(Q);
        acked = (sda_bus == 1'b0);
        w(Q); scl_m = 1'b0; w(Q);
    endtask

    task automatic recv_byte(input bit give_ack, output logic [7:0] d);
        for (int i = 7; i >= 0; i--) begin
            logic first;
            sda_m = 1'b1; w(Q); scl_m = 1'b1; w(1);
            first = sda_bus;
            w(Q - 1);
            d[i] = sda_bus;
            w(Q - 1);
            if (sda_bus !== first) r11_bad++;
            w(1); scl_m = 1'b0; w(Q);
        end
        rd_seed = rd_seed + 8'h01;
        sda_m = give_ack ? 1'b0 : 1'b1; w(Q); scl_m = 1'b1; w(2 * Q); scl_m = 1'b0; w(Q);
        sda_m = 1'b1;
    endtask

    task automatic write_txn(input logic [7:0] id, input logic [7:0] a, input logic [7:0] d,
                             input bit glitch, input string tag);
        bit ack;
        bus_start();
        send_byte(id, 1'b0, ack); chk({tag, " id ack"}, ack, 1);
        send_byte(a, glitch, ack); chk({tag, " addr ack"}, ack, 1);
        exp_wr.push_back({a, d});
        send_byte(d, 1'b0, ack); chk({tag, " data ack"}, ack, 1);
        bus_stop(); stops_exp++;
        w(20);
        chk({tag, " R8 stop pulse count"}, stops_seen, stops_exp);
        chk({tag, " write seen"}, exp_wr.size(), 0);
    endtask

    initial begin
        repeat (150000) @(negedge clk);
        n_fail++;
        $display("FAIL watchdog actual=running expected=done");
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

    initial begin
        bit ack;
        logic [7:0] d;
        w(8);
        // R1 reset state
        chk("R1 sda_drive_low", sda_drive_low, 0);
        chk("R1 reg_we", reg_we, 0);
        chk("R1 stop_pulse", stop_pulse, 0);
        rst_n = 1'b1;
        w(10);
        chk("R1 after release", {sda_drive_low, reg_we, stop_pulse}, 0);

        // R2/R4 plain write
        write_txn(8'h50, 8'h05, 8'h3C, 1'b0, "R4 write");

        // R5 extra data byte not acked
        bus_start();
        send_byte(8'h50, 1'b0, ack); chk("R5 id ack", ack, 1);
        send_byte(8'h07, 1'b0, ack); chk("R5 addr ack", ack, 1);
        exp_wr.push_back(16'h0781);
        send_byte(8'h81, 1'b0, ack); chk("R5 data ack", ack, 1);
        send_byte(8'hFF, 1'b0, ack); chk("R5 extra byte nack", ack, 0);
        bus_stop(); stops_exp++; w(20);
        chk("R5 one write", exp_wr.size(), 0);
        chk("R8 stop after write", stops_seen, stops_exp);

        // R2 bad identification: bit1 set, then wrong prefix
        bus_start();
        send_byte(8'h52, 1'b0, ack); chk("R2 bit1 set nack", ack, 0);
        send_byte(8'h05, 1'b0, ack); chk("R2 stays idle", ack, 0);
        bus_stop();
        bus_start();
        send_byte(8'h60, 1'b0, ack); chk("R2 bad prefix nack", ack, 0);
        bus_stop(); w(20);
        chk("R8 no pulse for rejected", stops_seen, stops_exp);

        // R3 pin latched at START
        addr_pin = 1'b1;
        bus_start();
        addr_pin = 1'b0;
        send_byte(8'h54, 1'b0, ack); chk("R3 latched pin id ack", ack, 1);
        send_byte(8'h09, 1'b0, ack); chk("R3 addr ack", ack, 1);
        exp_wr.push_back(16'h095A);
        send_byte(8'h5A, 1'b0, ack); chk("R3 data ack", ack, 1);
        bus_stop(); stops_exp++; w(20);
        chk("R3 write seen", exp_wr.size(), 0);
        bus_start();
        send_byte(8'h54, 1'b0, ack); chk("R3 pin 0 rejects A1=1 id", ack, 0);
        bus_stop();

        // R6/R7 read stream
        rd_seed = 8'h00;
        bus_start();
        send_byte(8'h50, 1'b0, ack); chk("R6 id ack", ack, 1);
        send_byte(8'h12, 1'b0, ack); chk("R6 addr ack", ack, 1);
        bus_start();
        send_byte(8'h51, 1'b0, ack); chk("R6 read id ack", ack, 1);
        recv_byte(1'b1, d); chk("R6 byte0", d, 8'h12);
        recv_byte(1'b1, d); chk("R7 byte1 after ack", d, 8'h13);
        recv_byte(1'b0, d); chk("R7 byte2", d, 8'h14);
        w(Q);
        chk("R7 released after nack", sda_drive_low, 0);
        bus_stop(); w(20);
        chk("R8 no pulse after read", stops_seen, stops_exp);
        chk("R11 sda steady in scl high", r11_bad, 0);

        // R9 busy ignores START
        busy = 1'b1;
        bus_start();
        send_byte(8'h50, 1'b0, ack); chk("R9 busy nack", ack, 0);
        bus_stop();
        busy = 1'b0;
        w(20);
        chk("R9 no pulse", stops_seen, stops_exp);

        // R10 SCL spike shorter than filter inside the address byte
        write_txn(8'h50, 8'h0A, 8'h77, 1'b1, "R10 glitch");

        chk("R4 no pending writes", exp_wr.size(), 0);
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end
endmodule